// File: doc/BRIEF.md
# DMA Interrupt Status Unit

This unit sits beside a bank of DMA channels and turns their per-channel event pulses into CPU interrupt state. There are four event classes: transfer completion, source-side error, destination-side error and configuration error. Each class keeps two bit-vectors with one bit per channel. The raw vector records every event. The reported vector records only the events that should interrupt the CPU. A single registered interrupt line is high while any reported bit is set.

Software clears pending state by writing ones to a class's raw-register address. This write-one-to-clear removes the selected bits from both the raw and the reported view. The unit also shows a per-channel busy word taken from the channels. It holds an arbitration-mode setting and a group-priority setting, and drives both to the channel arbiter.

The register interface decodes only the global region at byte offsets 0x800 and above. This region lies above the per-channel windows, which repeat every 0x40 bytes from the block base. Reads are registered.

Top module: `dmairq_top`

## Requirements
- R1: Synchronous active-low reset clears every raw and reported bit, the arbitration mode, the group priority, the read data and `irq`.
- R2: An event pulse on channel i sets bit i of that class's raw vector at the next clock edge. The raw vectors read at 0x810 (completion), 0x814 (source error), 0x818 (destination error) and 0x81C (configuration error), with bit i for channel i and bits above the channel count read as zero.
- R3: A completion sets reported bit i only if `ev_done_ie[i]` is high in the same cycle. Every error event sets its reported bit. The reported vectors read at 0x800, 0x804, 0x808 and 0x80C in the same class order as R2.
- R4: A write to a raw address clears, in both the raw and the reported vector of that class, every bit written as 1. Bits written as 0 are unchanged, and writing all ones clears every channel.
- R5: Writes to the reported addresses 0x800 to 0x80C change no state.
- R6: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: `irq` is a register that, one cycle later, equals the OR of all reported bits of all classes. A completion without its enable never raises it.
- R8: A read of 0x820 returns `ch_busy`, bit i for channel i, as sampled at the read edge.
- R9: 0x828 holds the arbitration mode, which drives `arb_mode` and resets to 0 (all channels equal). 0x824 holds the group priority, which drives `grp_prio`. Both read back what was written, truncated to their widths.
- R10: Read data appears in `reg_rdata` the cycle after `reg_rd_en`. Unmapped addresses read zero, and `reg_rdata` is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_done | input | NUM_CH | Segment-complete pulse per channel |
| ev_done_ie | input | NUM_CH | Interrupt-enable field of the completing segment |
| ev_src_err | input | NUM_CH | Source error pulse per channel |
| ev_dst_err | input | NUM_CH | Destination error pulse per channel |
| ev_cfg_err | input | NUM_CH | Configuration error pulse per channel |
| ch_busy | input | NUM_CH | Channel enabled and running |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset from the block base |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| arb_mode | output | ARB_W | Arbitration mode setting |
| grp_prio | output | PRIO_W | Group priority setting |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The hardest case to reach from the ports is an event and a clearing write landing on the same channel bit in the same cycle, together with the irq falling edge that follows a full clear. A directed step forces the collision on one source-error bit. A later step wipes every class with all-ones writes and then watches irq drop one cycle later. The random phase keeps events sparse, at about one bit in eight, while aiming most writes at raw addresses, so collisions, partial clears and unqualified completions keep recurring. A bench model follows every cycle.

// File: rtl/dmairq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the DMA interrupt status unit.
// Assumes byte offsets relative to the block base; the status region starts at 0x800.
package dmairq_pkg;
    localparam int CLASS_CNT = 4;

    // Class order fixes both the register order and the packing of the flat vectors.
    typedef enum logic [1:0] {
        CL_DONE   = 2'd0,
        CL_SRCERR = 2'd1,
        CL_DSTERR = 2'd2,
        CL_CFGERR = 2'd3
    } irq_class_e;

    localparam int unsigned OFS_REPORT = 32'h800;
    localparam int unsigned OFS_RAW    = 32'h810;
    localparam int unsigned OFS_BUSY   = 32'h820;
    localparam int unsigned OFS_PRIO   = 32'h824;
    localparam int unsigned OFS_ARB    = 32'h828;
    localparam int unsigned REG_STRIDE = 4;
endpackage

// File: rtl/dmairq_class_bank.sv
`timescale 1ns/1ps
// One interrupt class: a raw vector and a reported vector, one bit per channel.
// An event sets raw; an event with its qualifier also sets reported.
// A clear mask removes bits from both vectors; a set in the same cycle wins.
// Assumes events are single-cycle pulses from the channel logic.
module dmairq_class_bank #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_ev,
    input  logic [NUM_CH-1:0] set_qual,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] rep_q
);
    logic [NUM_CH-1:0] rep_set;

    // Qualified set for the reported view.
    always_comb rep_set = set_ev & set_qual;

    // Raw vector: clear first, then set, so a colliding event survives.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_mask) | set_ev;
    end

    // Reported vector: same ordering, set only by qualified events.
    always_ff @(posedge clk) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= (rep_q & ~clr_mask) | rep_set;
    end
endmodule

// File: rtl/dmairq_regs.sv
`timescale 1ns/1ps
// Register decode for the global status region.
// Produces per-class clear masks from writes to raw addresses, holds the
// arbitration and group-priority settings, and returns registered read data.
// Assumes NUM_CH, ARB_W and PRIO_W are no wider than DATA_W.
module dmairq_regs
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int ARB_W  = 2,
    parameter int PRIO_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [CLASS_CNT*NUM_CH-1:0] raw_flat,
    input  logic [CLASS_CNT*NUM_CH-1:0] rep_flat,
    input  logic [NUM_CH-1:0]           busy,
    output logic [CLASS_CNT*NUM_CH-1:0] clr_flat,
    output logic [DATA_W-1:0]           rdata,
    output logic [ARB_W-1:0]            arb_mode,
    output logic [PRIO_W-1:0]           grp_prio
);
    localparam logic [ADDR_W-1:0] A_BUSY = ADDR_W'(OFS_BUSY);
    localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(OFS_PRIO);
    localparam logic [ADDR_W-1:0] A_ARB  = ADDR_W'(OFS_ARB);

    logic [DATA_W-1:0] rd_next;
    logic              unused_wdata;

    // Address of register k in a bank of class registers.
    function automatic logic [ADDR_W-1:0] cls_addr(input int unsigned base, input int k);
        return ADDR_W'(base + REG_STRIDE * k);
    endfunction

    // Fold away write data bits above the widest field.
    assign unused_wdata = ^wdata;

    // One clear mask per class, taken from writes to its raw address.
    for (genvar k = 0; k < CLASS_CNT; k++) begin : g_clr
        assign clr_flat[k*NUM_CH +: NUM_CH] =
            (wr_en && addr == cls_addr(OFS_RAW, k)) ? wdata[NUM_CH-1:0] : '0;
    end

    // Arbitration mode register; 0 means equal priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                      arb_mode <= '0;
        else if (wr_en && addr == A_ARB) arb_mode <= wdata[ARB_W-1:0];
    end

    // Group priority register.
    always_ff @(posedge clk) begin
        if (!rst_n)                       grp_prio <= '0;
        else if (wr_en && addr == A_PRIO) grp_prio <= wdata[PRIO_W-1:0];
    end

    // Read multiplexer over the mapped registers; anything else reads zero.
    always_comb begin
        rd_next = '0;
        for (int k = 0; k < CLASS_CNT; k++) begin
            if (addr == cls_addr(OFS_REPORT, k)) rd_next = DATA_W'(rep_flat[k*NUM_CH +: NUM_CH]);
            if (addr == cls_addr(OFS_RAW, k))    rd_next = DATA_W'(raw_flat[k*NUM_CH +: NUM_CH]);
        end
        if (addr == A_BUSY) rd_next = DATA_W'(busy);
        if (addr == A_PRIO) rd_next = DATA_W'(grp_prio);
        if (addr == A_ARB)  rd_next = DATA_W'(arb_mode);
    end

    // Registered read data, zero after a cycle with no read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
        else            rdata <= '0;
    end
endmodule

// File: rtl/dmairq_line.sv
`timescale 1ns/1ps
// Interrupt line: a registered OR of every reported bit of every class.
// Assumes the reported vectors come straight from flops, so one cycle of latency is enough.
module dmairq_line #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pend,
    output logic             irq
);
    // Flop the OR reduction; low through and after reset until something is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |pend;
    end
endmodule

// File: rtl/dmairq_top.sv
`timescale 1ns/1ps
// DMA interrupt status unit: four event classes, each with a raw and a reported
// vector, cleared by writing ones to the raw address, and a single interrupt line.
// Assumes event inputs are single-cycle pulses and one register access per cycle.
module dmairq_top
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int ARB_W  = 2,
    parameter int PRIO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_done_ie,
    input  logic [NUM_CH-1:0] ev_src_err,
    input  logic [NUM_CH-1:0] ev_dst_err,
    input  logic [NUM_CH-1:0] ev_cfg_err,
    input  logic [NUM_CH-1:0] ch_busy,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [ARB_W-1:0]  arb_mode,
    output logic [PRIO_W-1:0] grp_prio,
    output logic              irq
);
    localparam int FLAT_W = CLASS_CNT * NUM_CH;

    logic [FLAT_W-1:0] ev_flat;
    logic [FLAT_W-1:0] qual_flat;
    logic [FLAT_W-1:0] clr_flat;
    logic [FLAT_W-1:0] raw_flat;
    logic [FLAT_W-1:0] rep_flat;

    // Pack events in class order; only completions carry a qualifier.
    assign ev_flat   = {ev_cfg_err, ev_dst_err, ev_src_err, ev_done};
    assign qual_flat = {{(FLAT_W-NUM_CH){1'b1}}, ev_done_ie};

    // One status bank per class.
    for (genvar k = 0; k < CLASS_CNT; k++) begin : g_bank
        dmairq_class_bank #(.NUM_CH(NUM_CH)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_ev   (ev_flat[k*NUM_CH +: NUM_CH]),
            .set_qual (qual_flat[k*NUM_CH +: NUM_CH]),
            .clr_mask (clr_flat[k*NUM_CH +: NUM_CH]),
            .raw_q    (raw_flat[k*NUM_CH +: NUM_CH]),
            .rep_q    (rep_flat[k*NUM_CH +: NUM_CH])
        );
    end

    dmairq_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ARB_W  (ARB_W),
        .PRIO_W (PRIO_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .raw_flat (raw_flat),
        .rep_flat (rep_flat),
        .busy     (ch_busy),
        .clr_flat (clr_flat),
        .rdata    (reg_rdata),
        .arb_mode (arb_mode),
        .grp_prio (grp_prio)
    );

    dmairq_line #(.WIDTH(FLAT_W)) line_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (rep_flat),
        .irq   (irq)
    );
endmodule

// File: rtl/dmairq_checker.sv
`timescale 1ns/1ps
// Property checker for dmairq_top, attached by bind below.
// Assumes the flat vectors pack classes in the package order, channel i at bit i.
module dmairq_checker
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int ARB_W  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CH-1:0]           ev_done,
    input logic [NUM_CH-1:0]           ev_done_ie,
    input logic [NUM_CH-1:0]           ev_src_err,
    input logic [NUM_CH-1:0]           ev_dst_err,
    input logic [NUM_CH-1:0]           ev_cfg_err,
    input logic                        reg_wr_en,
    input logic                        reg_rd_en,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic [DATA_W-1:0]           reg_rdata,
    input logic [ARB_W-1:0]            arb_mode,
    input logic [CLASS_CNT*NUM_CH-1:0] raw_flat,
    input logic [CLASS_CNT*NUM_CH-1:0] rep_flat,
    input logic                        irq
);
    localparam logic [ADDR_W-1:0] A_RAW_DONE = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_REP_LO   = ADDR_W'(OFS_REPORT);
    localparam logic [ADDR_W-1:0] A_REP_HI   = ADDR_W'(OFS_REPORT + 3 * REG_STRIDE);

    logic [CLASS_CNT*NUM_CH-1:0] ev_all;
    logic [NUM_CH-1:0]           raw_done;
    logic [NUM_CH-1:0]           rep_done;

    assign ev_all   = {ev_cfg_err, ev_dst_err, ev_src_err, ev_done};
    assign raw_done = raw_flat[NUM_CH-1:0];
    assign rep_done = rep_flat[NUM_CH-1:0];

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq == 1'b0 && raw_flat == '0 && rep_flat == '0));

    p_event_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_all) |=> ((raw_flat & $past(ev_all)) == $past(ev_all)));

    p_rep_needs_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_flat & ~raw_flat) == '0);

    p_done_needs_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rep_done & ~$past(rep_done) & ~$past(ev_done & ev_done_ie)) == '0));

    p_w1c_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_RAW_DONE)
        |=> ((raw_done & $past(reg_wdata[NUM_CH-1:0] & ~ev_done)) == '0));

    p_report_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr >= A_REP_LO && reg_addr <= A_REP_HI && ev_all == '0)
        |=> $stable(rep_flat) && $stable(raw_flat));

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && (ev_done & reg_wdata[NUM_CH-1:0]) != '0)
        |=> ((raw_done & $past(ev_done)) == $past(ev_done)));

    p_irq_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|rep_flat)));

    p_arb_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (arb_mode == '0));

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> (reg_rdata == '0));
endmodule

bind dmairq_top dmairq_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ARB_W  (ARB_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_done    (ev_done),
    .ev_done_ie (ev_done_ie),
    .ev_src_err (ev_src_err),
    .ev_dst_err (ev_dst_err),
    .ev_cfg_err (ev_cfg_err),
    .reg_wr_en  (reg_wr_en),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .arb_mode   (arb_mode),
    .raw_flat   (raw_flat),
    .rep_flat   (rep_flat),
    .irq        (irq)
);

// File: tb/dmairq_top_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners, then seeded random traffic, against a cycle model.
module dmairq_top_tb_top;
    localparam int N    = 8;
    localparam int AW   = 12;
    localparam int DW   = 32;
    localparam int ARBW = 2;
    localparam int PRW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ev_done = '0, ev_done_ie = '0, ev_src_err = '0;
    logic [N-1:0]  ev_dst_err = '0, ev_cfg_err = '0, ch_busy = '0;
    logic          reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [ARBW-1:0] arb_mode;
    logic [PRW-1:0]  grp_prio;
    logic            irq;

    // Model state
    logic [N-1:0]    m_raw [4];
    logic [N-1:0]    m_rep [4];
    logic [ARBW-1:0] m_arb;
    logic [PRW-1:0]  m_prio;
    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    dmairq_top #(.NUM_CH(N), .ADDR_W(AW), .DATA_W(DW), .ARB_W(ARBW), .PRIO_W(PRW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_done_ie(ev_done_ie),
        .ev_src_err(ev_src_err), .ev_dst_err(ev_dst_err), .ev_cfg_err(ev_cfg_err),
        .ch_busy(ch_busy), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .arb_mode(arb_mode), .grp_prio(grp_prio), .irq(irq)
    );

    // Expected read value of the model at address a.
    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a, input logic [N-1:0] bz);
        logic [DW-1:0] v = '0;
        for (int k = 0; k < 4; k++) begin
            if (a == AW'(12'h800 + 4*k)) v = DW'(m_rep[k]);
            if (a == AW'(12'h810 + 4*k)) v = DW'(m_raw[k]);
        end
        if (a == 12'h820) v = DW'(bz);
        if (a == 12'h824) v = DW'(m_prio);
        if (a == 12'h828) v = DW'(m_arb);
        return v;
    endfunction

    function automatic logic model_any();
        logic r = 1'b0;
        for (int k = 0; k < 4; k++) r = r | (|m_rep[k]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, step the model, check at the next falling edge.
    task automatic cyc(input logic [N-1:0] d, input logic [N-1:0] ie, input logic [N-1:0] se,
                       input logic [N-1:0] de, input logic [N-1:0] ce, input logic [N-1:0] bz,
                       input logic wr, input logic rd, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input string tag);
        logic [DW-1:0] exp_rd;
        logic          exp_irq;
        logic [N-1:0]  ev [4];
        logic [N-1:0]  clr;
        ev_done = d; ev_done_ie = ie; ev_src_err = se; ev_dst_err = de; ev_cfg_err = ce;
        ch_busy = bz; reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = wd;
        exp_rd  = rd ? model_read(a, bz) : '0;
        exp_irq = model_any();
        ev[0] = d; ev[1] = se; ev[2] = de; ev[3] = ce;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            clr = (wr && a == AW'(12'h810 + 4*k)) ? wd[N-1:0] : '0;
            m_raw[k] = (m_raw[k] & ~clr) | ev[k];
            m_rep[k] = (m_rep[k] & ~clr) | ((k == 0) ? (ev[k] & ie) : ev[k]);
        end
        if (wr && a == 12'h828) m_arb  = wd[ARBW-1:0];
        if (wr && a == 12'h824) m_prio = wd[PRW-1:0];
        check(rd ? tag : "R10 idle read data", reg_rdata, exp_rd);
        check("R7 irq", DW'(irq), DW'(exp_irq));
        check("R9 arb/prio outputs", DW'({grp_prio, arb_mode}), DW'({m_prio, m_arb}));
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        cyc('0, '0, '0, '0, '0, '0, 1'b0, 1'b1, a, '0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
        cyc('0, '0, '0, '0, '0, '0, 1'b1, 1'b0, a, wd, tag);
    endtask

    function automatic logic [AW-1:0] pick_addr(input int unsigned r);
        case (r % 12)
            0: return 12'h800;  1: return 12'h804;  2: return 12'h808;  3: return 12'h80C;
            4: return 12'h810;  5: return 12'h814;  6: return 12'h818;  7: return 12'h81C;
            8: return 12'h820;  9: return 12'h824; 10: return 12'h828;
            default: return 12'h83C;
        endcase
    endfunction

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        for (int k = 0; k < 4; k++) begin m_raw[k] = '0; m_rep[k] = '0; end
        m_arb = '0; m_prio = '0;
        seed_dummy = $urandom(32'h1F2E3D);
        // Reset with events present; they must be ignored while in reset.
        @(negedge clk);
        ev_done = '1; ev_done_ie = '1; ev_src_err = '1;
        repeat (3) @(negedge clk);
        ev_done = '0; ev_done_ie = '0; ev_src_err = '0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", DW'(irq), '0);
        check("R1 rdata after reset", reg_rdata, '0);
        check("R1 arb after reset", DW'(arb_mode), '0);
        for (int k = 0; k < 11; k++) rd(pick_addr(k), "R1 register after reset");

        // R2: source error on channel 3 shows in raw 0x814.
        cyc('0, '0, 8'h08, '0, '0, '0, 1'b0, 1'b0, '0, '0, "R2");
        rd(12'h814, "R2 raw source error bit 3");
        cyc('0, '0, '0, 8'h81, 8'h40, '0, 1'b0, 1'b0, '0, '0, "R2");
        rd(12'h818, "R2 raw destination error");
        rd(12'h81C, "R2 raw config error");
        wr(12'h814, 32'hFFFF_FFFF, "R4"); wr(12'h818, 32'hFFFF_FFFF, "R4"); wr(12'h81C, 32'hFFFF_FFFF, "R4");
        rd(12'h804, "R4 reported source cleared");
        // R3: completion without enable is raw only and leaves irq low.
        cyc(8'h20, 8'h00, '0, '0, '0, '0, 1'b0, 1'b0, '0, '0, "R3");
        rd(12'h810, "R3 raw done without enable");
        rd(12'h800, "R3 reported done without enable");
        // R3: completion with enable is reported and raises irq.
        cyc(8'h02, 8'h02, '0, '0, '0, '0, 1'b0, 1'b0, '0, '0, "R3");
        rd(12'h800, "R3 reported done with enable");
        // R5: writes to reported addresses change nothing.
        wr(12'h800, 32'hFFFF_FFFF, "R5"); wr(12'h804, 32'hFFFF_FFFF, "R5");
        rd(12'h800, "R5 reported after ignored write");
        rd(12'h810, "R5 raw after ignored write");
        // R6: event and clear on the same bit; set wins.
        cyc('0, '0, 8'h04, '0, '0, '0, 1'b0, 1'b0, '0, '0, "R6");
        cyc('0, '0, 8'h04, '0, '0, '0, 1'b1, 1'b0, 12'h814, 32'h04, "R6 collide");
        rd(12'h814, "R6 raw set wins");
        rd(12'h804, "R6 reported set wins");
        // R4: partial clear, then all ones on every raw register; irq drops.
        wr(12'h810, 32'h20, "R4 partial");
        rd(12'h810, "R4 partial clear keeps bit 1");
        for (int k = 0; k < 4; k++) wr(AW'(12'h810 + 4*k), 32'hFFFF_FFFF, "R4 clear all");
        rd(12'h800, "R4 all cleared");
        rd(12'h814, "R4 all cleared");
        // R9: arbitration and group priority.
        wr(12'h828, 32'hFFFF_FFFD, "R9"); wr(12'h824, 32'h1234_ABCD, "R9");
        rd(12'h828, "R9 arbitration readback");
        rd(12'h824, "R9 priority readback");
        // R8: busy word.
        cyc('0, '0, '0, '0, '0, 8'hA5, 1'b0, 1'b1, 12'h820, '0, "R8 busy word");
        cyc('0, '0, '0, '0, '0, 8'h3C, 1'b0, 1'b1, 12'h820, '0, "R8 busy word");
        // R10: unmapped addresses read zero.
        rd(12'h400, "R10 unmapped read");
        rd(12'h830, "R10 unmapped read");

        // Random phase.
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] d, ie, se, de, ce, bz;
            logic w, r;
            logic [AW-1:0] a;
            logic [DW-1:0] wd;
            d  = N'($urandom & $urandom & $urandom);
            ie = N'($urandom);
            se = N'($urandom & $urandom & $urandom);
            de = N'($urandom & $urandom & $urandom & $urandom);
            ce = N'($urandom & $urandom & $urandom & $urandom);
            bz = N'($urandom);
            w  = ($urandom % 3) == 0;
            r  = !w && ($urandom % 2 == 0);
            a  = ($urandom % 4 != 0) ? AW'(12'h810 + 4 * ($urandom % 4)) : pick_addr($urandom);
            if (r) a = pick_addr($urandom);
            wd = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
            cyc(d, ie, se, de, ce, bz, w, r, a, wd, "R2/R3/R4/R6 random read");
        end

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule